// File: doc/BRIEF.md
# Natural-Order Result Unloader

This block sits at the back end of a 1024-point radix-4 transform engine. The engine writes finished samples into an internal buffer in its own scrambled order. Each sample is a pair of 13-bit two's complement words, real and imaginary. When the engine signals that a block is complete, the unloader raises a ready flag and holds the block. A consumer starts the transfer by asserting an enable while the flag is high. The unloader then streams all 1024 samples on back-to-back cycles in natural index order.

The reordering is a base-4 digit reversal of the natural index, which matches a decimation-in-frequency write order. The first sample of a stream carries a start pulse, and every sample carries a valid strobe. An overflow flag captured with the block travels alongside each sample of that block. A synchronous clear abandons any transfer at once. A completion notice that arrives during a stream is held back until the stream has ended.

Top module: `nr_unloader`

## Requirements
- R1: While `rst` or `clr` is high at a rising edge, `ready`, `blk_start`, `smp_valid` and `out_ovf` are low after that edge.
- R2: A `wr_done` pulse sampled while no block is held and no stream is running sets `ready` high after that same edge.
- R3: An edge that samples `rd_en` high while `ready` is high accepts the block, and `ready` is low after that edge.
- R4: After an accepting edge, `smp_valid` is high for exactly 1024 consecutive cycles, beginning after the next rising edge.
- R5: `blk_start` is high only together with the first sample of a stream (natural index 0), for one cycle.
- R6: Natural-index sample k presents the buffer word at address rev(k). Here rev(k) maps the base-4 digit in bits [2d+1:2d] of k to bits [2(4-d)+1:2(4-d)], for d = 0..4. `out_re` and `out_im` are the words written through `wr_re`/`wr_im` at that address.
- R7: `out_ovf` equals the `wr_ovf` value sampled with the block's `wr_done` pulse on every valid sample of that block, and is low whenever `smp_valid` is low.
- R8: `rd_en` has no effect while `ready` is low: it starts no stream when idle, and it does not alter or restart a stream that is running.
- R9: A `wr_done` pulse during a stream keeps `ready` low until the last sample of that stream. `ready` rises on the same edge that presents sample 1023, and the next stream carries the new block's overflow flag.
- R10: `clr` during a stream drops `smp_valid`, `blk_start` and `ready` after the edge that samples it. No further samples appear until a new block is completed and accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the handshake and any transfer |
| wr_en | input | 1 | Buffer write strobe from the engine |
| wr_addr | input | 10 | Buffer write address (engine order) |
| wr_re | input | 13 | Real word to write |
| wr_im | input | 13 | Imaginary word to write |
| wr_done | input | 1 | One-cycle pulse: block complete |
| wr_ovf | input | 1 | Overflow status of the completed block, sampled with `wr_done` |
| rd_en | input | 1 | Consumer download enable |
| ready | output | 1 | A full block is waiting to be read |
| blk_start | output | 1 | Marks natural-index sample 0 |
| smp_valid | output | 1 | Sample strobe |
| out_re | output | 13 | Real output word, two's complement |
| out_im | output | 13 | Imaginary output word, two's complement |
| out_ovf | output | 1 | Overflow flag of the block being streamed |

## Verification
The properties assume that `wr_done` is a single-cycle pulse and that the engine does not rewrite buffer words while those words are being streamed. The bench therefore writes a whole block before pulsing completion. During a stream it only pulses `wr_done`, without writing. The properties also assume `rd_en` is dropped after acceptance. The idle-enable property holds only when no stream is between acceptance and its first sample, and the stimulus raises `rd_en` in that gap only while `ready` is high.

// File: rtl/ulr_pkg.sv
package ulr_pkg;

    localparam int unsigned DIGIT_BITS = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READY  = 2'd1,
        ST_STREAM = 2'd2
    } ulr_state_e;

    typedef struct packed {
        logic first;
        logic last;
    } idx_flags_t;

    function automatic int unsigned addr_width(input int unsigned digits);
        return digits * DIGIT_BITS;
    endfunction

endpackage

// File: rtl/ulr_store.sv
module ulr_store #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 13
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_re,
    input  logic [DW-1:0] wr_im,
    input  logic          rd_act,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_re,
    output logic [DW-1:0] rd_im
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned WW    = 2 * DW;

    logic [WW-1:0] mem [DEPTH];
    logic [WW-1:0] rword;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= {wr_re, wr_im};
        end
    end

    always_ff @(posedge clk) begin
        if (rd_act) begin
            rword <= mem[raddr];
        end
    end

    assign rd_re = rword[WW-1:DW];
    assign rd_im = rword[DW-1:0];
endmodule

// File: rtl/ulr_addr_gen.sv
module ulr_addr_gen
    import ulr_pkg::*;
#(
    parameter int unsigned DIGITS = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          accept,
    input  logic                          rd_act,
    output logic [DIGITS*DIGIT_BITS-1:0]  raddr,
    output idx_flags_t                    flags
);
    localparam int unsigned AW = DIGITS * DIGIT_BITS;

    logic [AW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clr || accept) begin
            idx <= '0;
        end else if (rd_act) begin
            idx <= idx + 1'b1;
        end
    end

    // digit d of the natural index lands in digit DIGITS-1-d of the address
    for (genvar d = 0; d < DIGITS; d++) begin : g_rev
        assign raddr[d*DIGIT_BITS +: DIGIT_BITS] =
            idx[(DIGITS-1-d)*DIGIT_BITS +: DIGIT_BITS];
    end

    assign flags.first = (idx == '0);
    assign flags.last  = (idx == {AW{1'b1}});
endmodule

// File: rtl/ulr_ctrl.sv
module ulr_ctrl
    import ulr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr_done,
    input  logic       wr_ovf,
    input  logic       rd_en,
    input  idx_flags_t flags,
    output logic       rd_act,
    output logic       accept,
    output logic       ready,
    output logic       blk_start,
    output logic       smp_valid,
    output logic       out_ovf
);
    ulr_state_e st;
    logic       pend;
    logic       pend_ovf;
    logic       hold_ovf;
    logic       str_ovf;

    assign rd_act = (st == ST_STREAM);
    assign ready  = (st == ST_READY);
    assign accept = ready && rd_en;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st        <= ST_IDLE;
            pend      <= 1'b0;
            pend_ovf  <= 1'b0;
            hold_ovf  <= 1'b0;
            str_ovf   <= 1'b0;
            smp_valid <= 1'b0;
            blk_start <= 1'b0;
            out_ovf   <= 1'b0;
        end else begin
            smp_valid <= rd_act;
            blk_start <= rd_act && flags.first;
            out_ovf   <= rd_act && str_ovf;
            unique case (st)
                ST_IDLE: begin
                    if (wr_done) begin
                        st       <= ST_READY;
                        hold_ovf <= wr_ovf;
                    end
                end
                ST_READY: begin
                    if (rd_en) begin
                        st      <= ST_STREAM;
                        str_ovf <= hold_ovf;
                        if (wr_done) begin
                            pend     <= 1'b1;
                            pend_ovf <= wr_ovf;
                        end
                    end else if (wr_done) begin
                        hold_ovf <= wr_ovf;
                    end
                end
                ST_STREAM: begin
                    if (flags.last) begin
                        pend <= 1'b0;
                        if (pend || wr_done) begin
                            st       <= ST_READY;
                            hold_ovf <= wr_done ? wr_ovf : pend_ovf;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (wr_done) begin
                        pend     <= 1'b1;
                        pend_ovf <= wr_ovf;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nr_unloader.sv
module nr_unloader
    import ulr_pkg::*;
#(
    parameter  int unsigned DIGITS = 5,
    parameter  int unsigned DW     = 13,
    localparam int unsigned AW     = DIGITS * DIGIT_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_re,
    input  logic [DW-1:0] wr_im,
    input  logic          wr_done,
    input  logic          wr_ovf,
    input  logic          rd_en,
    output logic          ready,
    output logic          blk_start,
    output logic          smp_valid,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic          out_ovf
);
    logic          rd_act;
    logic          accept;
    logic [AW-1:0] raddr;
    idx_flags_t    flags;

    ulr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .wr_done   (wr_done),
        .wr_ovf    (wr_ovf),
        .rd_en     (rd_en),
        .flags     (flags),
        .rd_act    (rd_act),
        .accept    (accept),
        .ready     (ready),
        .blk_start (blk_start),
        .smp_valid (smp_valid),
        .out_ovf   (out_ovf)
    );

    ulr_addr_gen #(.DIGITS(DIGITS)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .accept (accept),
        .rd_act (rd_act),
        .raddr  (raddr),
        .flags  (flags)
    );

    ulr_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_re   (wr_re),
        .wr_im   (wr_im),
        .rd_act  (rd_act),
        .raddr   (raddr),
        .rd_re   (out_re),
        .rd_im   (out_im)
    );
endmodule

// File: rtl/nr_unloader_chk.sv
module nr_unloader_chk #(
    parameter int unsigned AW = 10
) (
    input logic clk,
    input logic rst,
    input logic clr,
    input logic rd_en,
    input logic ready,
    input logic blk_start,
    input logic smp_valid,
    input logic out_ovf
);
    localparam int unsigned NPTS = 1 << AW;

    logic [AW:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (smp_valid) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    // R1
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ready && !smp_valid && !blk_start && !out_ovf));

    // R3
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && rd_en && !clr) |=> !ready);

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (run_cnt < NPTS));

    // R4
    run_full_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(smp_valid) && !$past(clr)) |-> (run_cnt == NPTS));

    // R5
    start_valid_chk: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> smp_valid);

    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        blk_start |=> !blk_start);

    // R7
    ovf_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> !out_ovf);

    // R8
    idle_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready) && rd_en && !smp_valid) |=> !smp_valid);
endmodule

bind nr_unloader nr_unloader_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .rd_en     (rd_en),
    .ready     (ready),
    .blk_start (blk_start),
    .smp_valid (smp_valid),
    .out_ovf   (out_ovf)
);

// File: tb/nr_unloader_bench.sv
module nr_unloader_bench;
    localparam int NPTS = 1024;
    localparam int DW   = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          wr_en = 1'b0;
    logic [9:0]    wr_addr = '0;
    logic [DW-1:0] wr_re = '0;
    logic [DW-1:0] wr_im = '0;
    logic          wr_done = 1'b0;
    logic          wr_ovf = 1'b0;
    logic          rd_en = 1'b0;
    logic          ready;
    logic          blk_start;
    logic          smp_valid;
    logic [DW-1:0] out_re;
    logic [DW-1:0] out_im;
    logic          out_ovf;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    nr_unloader u_nr_unloader (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im),
        .wr_done(wr_done), .wr_ovf(wr_ovf), .rd_en(rd_en),
        .ready(ready), .blk_start(blk_start), .smp_valid(smp_valid),
        .out_re(out_re), .out_im(out_im), .out_ovf(out_ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rev4(input int k);
        int r = 0;
        for (int d = 0; d < 5; d++) r = (r << 2) | ((k >> (2 * d)) & 3);
        return r;
    endfunction

    function automatic logic [DW-1:0] pat_re(input int a, input int seed);
        return DW'((a * 37 + seed * 101) & 13'h1fff);
    endfunction

    function automatic logic [DW-1:0] pat_im(input int a, input int seed);
        return DW'(((a * 11) ^ (seed * 4051)) & 13'h1fff);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_block(input int seed, input bit ovf);
        for (int a = 0; a < NPTS; a++) begin
            wr_en = 1'b1; wr_addr = 10'(a);
            wr_re = pat_re(a, seed); wr_im = pat_im(a, seed);
            tick();
        end
        wr_en = 1'b0;
        check(ready == 1'b0, "R2", "ready before done", int'(ready), 0);
        wr_done = 1'b1; wr_ovf = ovf;
        tick();
        wr_done = 1'b0; wr_ovf = 1'b0;
        check(ready == 1'b1, "R2", "ready after done", int'(ready), 1);
    endtask

    // accepts the held block and checks the whole stream
    task automatic run_stream(input int seed, input bit exp_ovf,
                              input int inject_at, input bit inj_ovf);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check(ready == 1'b0, "R3", "ready after accept", int'(ready), 0);
        check(smp_valid == 1'b0, "R4", "valid before first sample", int'(smp_valid), 0);
        for (int k = 0; k < NPTS; k++) begin
            tick();
            wr_done = 1'b0; wr_ovf = 1'b0; rd_en = 1'b0;
            check(smp_valid == 1'b1, "R4", $sformatf("valid k=%0d", k), int'(smp_valid), 1);
            check(blk_start == (k == 0), "R5", $sformatf("start k=%0d", k),
                  int'(blk_start), int'(k == 0));
            check(out_re == pat_re(rev4(k), seed), "R6", $sformatf("re k=%0d", k),
                  int'(out_re), int'(pat_re(rev4(k), seed)));
            check(out_im == pat_im(rev4(k), seed), "R6", $sformatf("im k=%0d", k),
                  int'(out_im), int'(pat_im(rev4(k), seed)));
            check(out_ovf == exp_ovf, "R7", $sformatf("ovf k=%0d", k),
                  int'(out_ovf), int'(exp_ovf));
            check(ready == (inject_at >= 0 && k == NPTS - 1), "R9",
                  $sformatf("ready k=%0d", k), int'(ready),
                  int'(inject_at >= 0 && k == NPTS - 1));
            if (k == 100) rd_en = 1'b1;  // R8: enable while streaming
            if (k == inject_at) begin
                wr_done = 1'b1; wr_ovf = inj_ovf;
            end
        end
        tick();
        check(smp_valid == 1'b0, "R4", "valid after 1024", int'(smp_valid), 0);
        check(out_ovf == 1'b0, "R7", "ovf after stream", int'(out_ovf), 0);
        check(ready == (inject_at >= 0), "R9", "ready after stream",
              int'(ready), int'(inject_at >= 0));
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
        check(smp_valid == 1'b0, "R1", "valid in reset", int'(smp_valid), 0);
        check(blk_start == 1'b0, "R1", "start in reset", int'(blk_start), 0);
        check(out_ovf == 1'b0, "R1", "ovf in reset", int'(out_ovf), 0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_idle_enable();
        rd_en = 1'b1;
        repeat (3) tick();
        rd_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(smp_valid == 1'b0, "R8", "valid with idle enable", int'(smp_valid), 0);
            check(ready == 1'b0, "R8", "ready with idle enable", int'(ready), 0);
            tick();
        end
    endtask

    task automatic t_basic();
        load_block(1, 1'b0);
        run_stream(1, 1'b0, -1, 1'b0);
        load_block(2, 1'b1);
        run_stream(2, 1'b1, -1, 1'b0);
    endtask

    task automatic t_pending();
        load_block(3, 1'b1);
        run_stream(3, 1'b1, 500, 1'b0);
        run_stream(3, 1'b0, -1, 1'b0);
    endtask

    task automatic t_clear();
        load_block(4, 1'b1);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        repeat (10) tick();
        check(smp_valid == 1'b1, "R10", "valid before clear", int'(smp_valid), 1);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        check(smp_valid == 1'b0, "R10", "valid after clear", int'(smp_valid), 0);
        check(blk_start == 1'b0, "R10", "start after clear", int'(blk_start), 0);
        check(ready == 1'b0, "R10", "ready after clear", int'(ready), 0);
        check(out_ovf == 1'b0, "R1", "ovf after clear", int'(out_ovf), 0);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            check(smp_valid == 1'b0, "R10", "no samples after clear", int'(smp_valid), 0);
            check(ready == 1'b0, "R10", "ready stays low", int'(ready), 0);
            tick();
        end
        load_block(5, 1'b0);
        run_stream(5, 1'b0, -1, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        tick();
        t_reset();
        t_idle_enable();
        t_basic();
        t_pending();
        t_clear();
        repeat (2) tick();
        finish_run();
    end
endmodule